// File: doc/BRIEF.md
# Fixed-Point Kalman Temperature Smoother

This block smooths a stream of signed temperature readings in millidegrees with a scalar Kalman filter in integer arithmetic. Each accepted reading is first guarded against outliers. Once the filter has warmed up, a reading that jumps far above the running estimate is pulled down to a small step above it. A reading that drops far below the estimate is pulled up to a small step below it. The limits and the step sizes differ for the two directions. The guarded reading is then blended with the previous estimate. The blend uses a gain scaled by 2^FRAC_SHIFT, and the gain comes from the running error covariance.

The first reading after reset seeds the previous estimate. That seed is capped at an ambient ceiling, so a wild first reading cannot anchor the filter high. The gain needs a division, and a one-bit-per-cycle restoring divider computes it. While the divider runs, the input is stalled. Each accepted reading produces exactly one filtered result, shown for one clock on a valid strobe. The result stays on the output bus until the next result replaces it.

Top module: `kalman_temp_smoother`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0 and `out_temp` is 0. The covariance restarts at COV_INIT (160), and the filter is unseeded with an empty warm-up count.
- R2: A reading is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle until the result appears, `in_ready` is 0, and any `in_temp` or `in_valid` activity in that window is not consumed.
- R3: `out_valid` is 1 for exactly one cycle, FRAC_SHIFT+2 clock edges after the accepting edge. `in_ready` returns to 1 in that same cycle.
- R4: For the first reading after reset, the previous estimate is taken as the smaller of the reading and SEED_CAP (85000). Later readings do not apply this cap.
- R5: Readings 1 to WARMUP+1 (1 to 101) after reset are never limited. Limiting applies to every reading from number WARMUP+2 (102) on.
- R6: While limiting applies, a reading more than RISE_LIMIT (30000) above the previous estimate is replaced by the previous estimate plus RISE_STEP (10000). A rise of exactly 30000 is kept.
- R7: While limiting applies, a reading more than FALL_LIMIT (15000) below the previous estimate is replaced by the previous estimate minus FALL_STEP (5000). A fall of exactly 15000 is kept.
- R8: The gain is floor(M*1024 / (M + 542)). Here M = P + 18 and P is the stored covariance. The gain is always below 1024.
- R9: The result is (prev*1024 + gain*(x - prev)) shifted right arithmetically by 10, where x is the guarded reading. The sum is formed in 64-bit signed arithmetic. The result always lies between prev and x.
- R10: After each reading, the covariance becomes ((1024 - gain) * M) >> 10.
- R11: The result becomes the previous estimate for the next reading. `out_temp` holds its value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A reading is offered |
| in_ready | output | 1 | Block can take a reading this cycle |
| in_temp | input | DATA_W | Signed reading in millidegrees |
| out_valid | output | 1 | One-cycle strobe: new filtered value |
| out_temp | output | DATA_W | Signed filtered estimate, held between strobes |

## Verification
The bench builds the block with its default parameters: a 32-bit sample path, a 16-bit covariance, a 10-bit gain scale, a warm-up of 100 readings, and limits of 30000/15000 with steps of 10000/5000. With these values the warm-up boundary lies only about 1300 cycles from reset, so the bench can check readings 101 and 102 against each other. It also drives rises and falls of exactly the limit and of the limit plus one. Early results are also checked against hand-computed values, which pins down the seed cap and the first two covariance updates.

// File: rtl/kts_pkg.sv
package kts_pkg;

  localparam int CALC_W = 64;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } kts_state_e;

  // Blend of prior and measurement, with a gain scaled by 2^frac
  function automatic logic signed [CALC_W-1:0] kts_estimate(
    input logic signed [CALC_W-1:0] prior,
    input logic signed [CALC_W-1:0] meas,
    input logic signed [CALC_W-1:0] gain,
    input int                       frac
  );
    logic signed [CALC_W-1:0] acc;
    acc = (prior <<< frac) + gain * (meas - prior);
    return acc >>> frac;
  endfunction

  // Covariance after the update: (unity - gain) * predicted, rescaled
  function automatic logic [CALC_W-1:0] kts_cov_next(
    input logic [CALC_W-1:0] pmid,
    input logic [CALC_W-1:0] gain,
    input int                frac
  );
    logic [CALC_W-1:0] unity;
    unity = CALC_W'(1) << frac;
    return ((unity - gain) * pmid) >> frac;
  endfunction

endpackage

// File: rtl/kts_outlier_guard.sv
module kts_outlier_guard #(
  parameter int DATA_W     = 32,
  parameter int SEED_CAP   = 85000,
  parameter int RISE_LIMIT = 30000,
  parameter int RISE_STEP  = 10000,
  parameter int FALL_LIMIT = 15000,
  parameter int FALL_STEP  = 5000
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] prior_i,
  input  logic                     seeded_i,
  input  logic                     clamp_en_i,
  output logic signed [DATA_W-1:0] base_o,
  output logic signed [DATA_W-1:0] meas_o
);

  localparam logic signed [DATA_W-1:0] CAP    = DATA_W'(SEED_CAP);
  localparam logic signed [DATA_W:0]   UP_LIM = (DATA_W+1)'(RISE_LIMIT);
  localparam logic signed [DATA_W:0]   DN_LIM = (DATA_W+1)'(FALL_LIMIT);

  logic signed [DATA_W:0] rise;
  logic signed [DATA_W:0] fall;

  // Seed on the first reading, capped at the ambient ceiling
  assign base_o = seeded_i ? prior_i : ((sample_i < CAP) ? sample_i : CAP);

  assign rise = $signed({sample_i[DATA_W-1], sample_i}) - $signed({base_o[DATA_W-1], base_o});
  assign fall = $signed({base_o[DATA_W-1], base_o}) - $signed({sample_i[DATA_W-1], sample_i});

  always_comb begin
    meas_o = sample_i;
    if (clamp_en_i && (rise > UP_LIM)) begin
      meas_o = base_o + DATA_W'(RISE_STEP);
    end else if (clamp_en_i && (fall > DN_LIM)) begin
      meas_o = base_o - DATA_W'(FALL_STEP);
    end
  end

endmodule

// File: rtl/kts_warmup.sv
module kts_warmup #(
  parameter int WARMUP = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic active_o
);

  localparam int CNT_W = $clog2(WARMUP + 2);

  logic [CNT_W-1:0] cnt_q;

  // Saturates one past the warm-up length; limiting starts from there
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i && !active_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign active_o = (cnt_q > CNT_W'(WARMUP));

endmodule

// File: rtl/kts_divider.sv
module kts_divider #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 18,
  parameter int QUO_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(QUO_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [QUO_W-1:0] low_q;
  logic [QUO_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  // The quotient fits in QUO_W bits, so the upper numerator bits
  // preload the remainder and only QUO_W steps remain
  assign trial = {rem_q, low_q[QUO_W-1]};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      low_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= DEN_W'(num_i[NUM_W-1:QUO_W]);
        low_q  <= num_i[QUO_W-1:0];
        den_q  <= den_i;
        quo_q  <= '0;
        cnt_q  <= CNT_W'(QUO_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quo_q <= {quo_q[QUO_W-2:0], fits};
        low_q <= low_q << 1;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

endmodule

// File: rtl/kalman_temp_smoother.sv
module kalman_temp_smoother
  import kts_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COV_W      = 16,
  parameter int FRAC_SHIFT = 10,
  parameter int Q_NOISE    = 18,
  parameter int R_NOISE    = 542,
  parameter int COV_INIT   = 160,
  parameter int SEED_CAP   = 85000,
  parameter int WARMUP     = 100,
  parameter int RISE_LIMIT = 30000,
  parameter int RISE_STEP  = 10000,
  parameter int FALL_LIMIT = 15000,
  parameter int FALL_STEP  = 5000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_temp,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_temp
);

  localparam int PM_W   = COV_W + 1;
  localparam int NUM_W  = PM_W + FRAC_SHIFT;
  localparam int DEN_W  = PM_W + 1;
  localparam int GAIN_W = FRAC_SHIFT + 1;

  kts_state_e state_q;

  logic signed [DATA_W-1:0] est_q;
  logic signed [DATA_W-1:0] base_q;
  logic signed [DATA_W-1:0] meas_q;
  logic signed [DATA_W-1:0] base_d;
  logic signed [DATA_W-1:0] meas_d;
  logic signed [DATA_W-1:0] est_d;
  logic [COV_W-1:0]         cov_q;
  logic [COV_W-1:0]         cov_d;
  logic [PM_W-1:0]          pmid_q;
  logic [PM_W-1:0]          pmid_d;
  logic [NUM_W-1:0]         num_d;
  logic [DEN_W-1:0]         den_d;
  logic [GAIN_W-1:0]        gain;
  logic                     accept;
  logic                     div_done;
  logic                     warm_active;
  logic                     seeded_q;
  logic                     clamp_q;
  logic                     seed_q;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  // Predicted covariance and the gain division operands
  assign pmid_d = PM_W'(cov_q) + PM_W'(Q_NOISE);
  assign num_d  = {pmid_d, {FRAC_SHIFT{1'b0}}};
  assign den_d  = DEN_W'(pmid_d) + DEN_W'(R_NOISE);

  kts_outlier_guard #(
    .DATA_W    (DATA_W),
    .SEED_CAP  (SEED_CAP),
    .RISE_LIMIT(RISE_LIMIT),
    .RISE_STEP (RISE_STEP),
    .FALL_LIMIT(FALL_LIMIT),
    .FALL_STEP (FALL_STEP)
  ) u_guard (
    .sample_i  (in_temp),
    .prior_i   (est_q),
    .seeded_i  (seeded_q),
    .clamp_en_i(warm_active),
    .base_o    (base_d),
    .meas_o    (meas_d)
  );

  kts_warmup #(
    .WARMUP(WARMUP)
  ) u_warmup (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (accept),
    .active_o(warm_active)
  );

  kts_divider #(
    .NUM_W(NUM_W),
    .DEN_W(DEN_W),
    .QUO_W(GAIN_W)
  ) u_divider (
    .clk    (clk),
    .rst    (rst),
    .start_i(accept),
    .num_i  (num_d),
    .den_i  (den_d),
    .done_o (div_done),
    .quot_o (gain)
  );

  assign est_d = DATA_W'(kts_estimate(CALC_W'(base_q), CALC_W'(meas_q),
                                      CALC_W'(gain), FRAC_SHIFT));
  assign cov_d = COV_W'(kts_cov_next(CALC_W'(pmid_q), CALC_W'(gain), FRAC_SHIFT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      est_q     <= '0;
      base_q    <= '0;
      meas_q    <= '0;
      pmid_q    <= '0;
      cov_q     <= COV_W'(COV_INIT);
      seeded_q  <= 1'b0;
      clamp_q   <= 1'b0;
      seed_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        base_q   <= base_d;
        meas_q   <= meas_d;
        pmid_q   <= pmid_d;
        clamp_q  <= warm_active;
        seed_q   <= !seeded_q;
        seeded_q <= 1'b1;
        state_q  <= ST_DIV;
      end
      if (div_done) begin
        est_q     <= est_d;
        cov_q     <= cov_d;
        out_valid <= 1'b1;
        state_q   <= ST_IDLE;
      end
    end
  end

  assign out_temp = est_q;

endmodule

// File: rtl/kts_checker.sv
module kts_checker #(
  parameter int DATA_W     = 32,
  parameter int FRAC_SHIFT = 10,
  parameter int SEED_CAP   = 85000,
  parameter int RISE_LIMIT = 30000,
  parameter int FALL_LIMIT = 15000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_temp,
  input logic signed [DATA_W-1:0] base_q,
  input logic signed [DATA_W-1:0] meas_q,
  input logic [FRAC_SHIFT:0]      gain,
  input logic                     div_done,
  input logic                     clamp_q,
  input logic                     seed_q
);

  logic signed [DATA_W:0]   up;
  logic signed [DATA_W:0]   down;
  logic signed [DATA_W-1:0] lo;
  logic signed [DATA_W-1:0] hi;

  assign up   = $signed({meas_q[DATA_W-1], meas_q}) - $signed({base_q[DATA_W-1], base_q});
  assign down = $signed({base_q[DATA_W-1], base_q}) - $signed({meas_q[DATA_W-1], meas_q});
  assign lo   = (base_q < meas_q) ? base_q : meas_q;
  assign hi   = (base_q < meas_q) ? meas_q : base_q;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R3

  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready); // R3

  AST_SEED_CAP: assert property (@(posedge clk) disable iff (rst)
    (div_done && seed_q) |-> (base_q <= DATA_W'(SEED_CAP))); // R4

  AST_RISE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (div_done && clamp_q) |-> (up <= (DATA_W+1)'(RISE_LIMIT))); // R6

  AST_FALL_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (div_done && clamp_q) |-> (down <= (DATA_W+1)'(FALL_LIMIT))); // R7

  AST_GAIN_BELOW_UNITY: assert property (@(posedge clk) disable iff (rst)
    div_done |-> (gain < (FRAC_SHIFT+1)'(1 << FRAC_SHIFT))); // R8

  AST_EST_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_temp >= lo) && (out_temp <= hi))); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_temp)); // R11

endmodule

bind kalman_temp_smoother kts_checker #(
  .DATA_W    (DATA_W),
  .FRAC_SHIFT(FRAC_SHIFT),
  .SEED_CAP  (SEED_CAP),
  .RISE_LIMIT(RISE_LIMIT),
  .FALL_LIMIT(FALL_LIMIT)
) u_kts_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_temp (out_temp),
  .base_q   (base_q),
  .meas_q   (meas_q),
  .gain     (gain),
  .div_done (div_done),
  .clamp_q  (clamp_q),
  .seed_q   (seed_q)
);

// File: tb/test_kalman_temp_smoother.sv
module test_kalman_temp_smoother;

  localparam int     DW   = 32;
  localparam int     LAT  = 12;      // gain scale bits + 2
  localparam longint QN   = 18;
  localparam longint RN   = 542;
  localparam longint P0   = 160;
  localparam longint CAP  = 85000;
  localparam int     WARM = 100;
  localparam longint RL   = 30000;
  localparam longint RS   = 10000;
  localparam longint FL   = 15000;
  localparam longint FS   = 5000;

  logic                 clk      = 1'b0;
  logic                 rst      = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_temp  = '0;
  logic                 in_ready;
  logic                 out_valid;
  logic signed [DW-1:0] out_temp;

  always #10 clk = ~clk;

  kalman_temp_smoother i_kalman_temp_smoother (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_temp  (in_temp),
    .out_valid(out_valid),
    .out_temp (out_temp)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  // Behavioural reference state
  longint m_last, m_p, m_temp, m_pending;
  int     m_n, m_cnt;
  bit     m_seeded, m_ready, m_valid;
  bit     live = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit     rdy_b;
    longint x, pm, g;
    if (rst) begin
      live = 1'b1; m_last = 0; m_p = P0; m_n = 0; m_seeded = 1'b0;
      m_ready = 1'b1; m_valid = 1'b0; m_temp = 0; m_cnt = 0; m_pending = 0;
    end else begin
      rdy_b   = m_ready;
      m_valid = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_valid = 1'b1; m_temp = m_pending; m_ready = 1'b1;
        end
      end
      if (in_valid && rdy_b) begin
        x = longint'(in_temp);
        if (!m_seeded) begin
          m_last = (x < CAP) ? x : CAP;
          m_seeded = 1'b1;
        end
        if (m_n > WARM) begin
          if (x - m_last > RL) x = m_last + RS;
          else if (m_last - x > FL) x = m_last - FS;
        end
        if (m_n <= WARM) m_n++;
        pm     = m_p + QN;
        g      = (pm * 1024) / (pm + RN);
        m_last = (m_last * 1024 + g * (x - m_last)) >>> 10;
        m_p    = ((1024 - g) * pm) >> 10;
        m_pending = m_last;
        m_cnt   = LAT;
        m_ready = 1'b0;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check({"R2 in_ready ", phase}, longint'(in_ready), longint'(m_ready));
      check({"R3 out_valid ", phase}, longint'(out_valid), longint'(m_valid));
      check({"R9 R11 out_temp ", phase}, longint'(out_temp), m_temp);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(longint x);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_temp = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sample(longint x);
    send(x);
    while (!out_valid) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 in_ready after reset", longint'(in_ready), 1);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_temp after reset", longint'(out_temp), 0);

    phase = "R4";
    sample(90000);
    check("R4 seed capped at ceiling", longint'(out_temp), 86235);

    do_reset();
    sample(2048);
    check("R4 seed below ceiling", longint'(out_temp), 2048);
    phase = "R8";
    sample(3072);
    check("R8 R10 second reading", longint'(out_temp), 2272);
    phase = "R10";
    sample(4096);
    check("R10 third reading", longint'(out_temp), 2637);

    do_reset();
    phase = "R5";
    for (int i = 1; i <= WARM; i++) sample(40000 + (i % 7) * 35);
    sample(m_last + 40000);            // reading 101: not limited
    sample(m_last + 40000);            // reading 102: limited
    phase = "R6";
    sample(m_last + RL);
    sample(m_last + RL + 1);
    sample(m_last + 90000);
    phase = "R7";
    sample(m_last - FL);
    sample(m_last - FL - 1);
    sample(m_last - 70000);

    phase = "R2";
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      in_valid = 1'b1;
      in_temp  = DW'(longint'($urandom_range(0, 200000)) - 60000);
      @(negedge clk);
    end
    in_valid = 1'b0;

    phase = "R9";
    for (int i = 0; i < 40; i++) begin
      sample(longint'($urandom_range(0, 160000)) - 40000);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    phase = "R1";
    send(50000);
    repeat (4) @(negedge clk);
    do_reset();
    check("R1 in_ready after mid-busy reset", longint'(in_ready), 1);
    check("R1 out_temp after mid-busy reset", longint'(out_temp), 0);
    phase = "R4";
    sample(-20000);
    check("R4 negative seed", longint'(out_temp), -20000);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule